// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that retires one instruction on every rising clock edge. It implements a compact subset of integer operations: unsigned add and subtract between registers, OR with an unsigned 16-bit constant, word load, word store, branch-on-equal and an absolute jump. The core holds its own program counter, a 32-entry register file, an arithmetic unit, immediate extension logic, the branch and jump target adders and a purely combinational opcode decoder. Instruction memory and data memory are word arrays inside the block.

While reset is held, a test loader writes words into either memory through a simple write port. After reset is released, the core fetches from word 0 and runs freely. The current program counter and the contents of any one register, selected by an input, are visible at debug outputs. Nothing else leaves the block, so results are observed through those two outputs.

Top module: `sc_cpu_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 and every register reads 0 afterwards.
- R2: Register 0 always reads as 0; an instruction that targets register 0 leaves it at 0.
- R3: Opcode 000000 with funct 100001 writes rs+rt into rd, and with funct 100011 writes rs−rt into rd, both modulo 2^32.
- R4: Opcode 001101 writes rs OR the zero-extended bits [15:0] into rt.
- R5: Opcode 100011 loads the data word at rs + sign-extended [15:0] into rt; opcode 101011 stores rt to that address. Data words are addressed by address bits [DMEM_AW+1:2].
- R6: Any instruction other than a taken branch or a jump advances the program counter by 4. Instructions are fetched with address bits [IMEM_AW+1:2].
- R7: Opcode 000100 compares rs with rt. When they are equal, the program counter becomes PC+4 plus the sign-extended offset shifted left by 2; otherwise it becomes PC+4. Backward offsets are allowed.
- R8: Opcode 000010 sets the program counter to {PC+4[31:28], bits [25:0], 2'b00}.
- R9: Any other opcode, and an opcode 000000 word with any funct other than the two in R3, changes no register and no memory word and only advances the program counter.
- R10: When `ld_en` is high and `rst` is high at a rising edge, `ld_data` is written to word `ld_addr` of the instruction memory (`ld_sel`=0) or of the data memory (`ld_sel`=1). When `rst` is low, the loader has no effect.
- R11: `dbg_reg_val` combinationally shows the register selected by `dbg_reg_sel`, and `dbg_pc` shows the current program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset; the loader is enabled while it is high |
| ld_en | input | 1 | Loader write strobe |
| ld_sel | input | 1 | Loader target: 0 instruction memory, 1 data memory |
| ld_addr | input | LD_AW | Loader word index |
| ld_data | input | 32 | Loader word value |
| dbg_reg_sel | input | 5 | Register index for the debug tap |
| dbg_reg_val | output | 32 | Value of the selected register |
| dbg_pc | output | 32 | Current program counter |

## Verification
On every cycle, the bound checker confirms that the next program counter follows from the current instruction word: a sequential step, a taken or untaken equal-compare branch, or a jump target. It also confirms that register 0 reads as zero, that unsupported opcodes and reset cycles write nothing, and that a register write and a memory store never happen together. The arithmetic results, the zero-extension of the OR constant, the sign-extended load and store addressing, the silent discard of writes to register 0 and of unsupported funct codes, and the loader having no effect while the core runs are visible only in the register values the bench's programs leave behind. The bench reads those values back through the debug tap.

// File: rtl/sc_cpu_pkg.sv
package sc_cpu_pkg;

    localparam int XLEN    = 32;
    localparam int NREGS   = 32;
    localparam int RIDX_W  = $clog2(NREGS);
    localparam int OP_W    = 6;
    localparam int FN_W    = 6;
    localparam int IMM_W   = 16;
    localparam int JT_W    = 26;

    localparam logic [OP_W-1:0] OPC_REG  = 6'b000000;
    localparam logic [OP_W-1:0] OPC_JMP  = 6'b000010;
    localparam logic [OP_W-1:0] OPC_BEQ  = 6'b000100;
    localparam logic [OP_W-1:0] OPC_ORI  = 6'b001101;
    localparam logic [OP_W-1:0] OPC_LDW  = 6'b100011;
    localparam logic [OP_W-1:0] OPC_STW  = 6'b101011;

    localparam logic [FN_W-1:0] FN_ADDU  = 6'b100001;
    localparam logic [FN_W-1:0] FN_SUBU  = 6'b100011;

    // ALU operation class chosen by the decoder
    typedef enum logic [1:0] {
        AOP_ADD   = 2'b00,
        AOP_SUB   = 2'b01,
        AOP_FUNCT = 2'b10,
        AOP_OR    = 2'b11
    } aop_e;

    // Function the ALU actually computes
    typedef enum logic [1:0] {
        AFN_ADD = 2'b00,
        AFN_SUB = 2'b01,
        AFN_OR  = 2'b10,
        AFN_NOP = 2'b11
    } afn_e;

    typedef struct packed {
        logic dst_is_rd;
        logic b_is_imm;
        logic imm_zext;
        logic wb_from_mem;
        logic reg_wr;
        logic mem_rd;
        logic mem_wr;
        logic is_branch;
        logic is_jump;
        aop_e aop;
    } ctrl_t;

    function automatic logic [XLEN-1:0] ext_imm(input logic [IMM_W-1:0] imm, input logic zext);
        ext_imm = zext ? {{(XLEN-IMM_W){1'b0}}, imm} : {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    endfunction

endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
    import sc_cpu_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output ctrl_t           ctrl
);
    always_comb begin
        ctrl = '0;
        ctrl.aop = AOP_ADD;
        unique case (opcode)
            OPC_REG: begin
                ctrl.dst_is_rd = 1'b1;
                ctrl.reg_wr    = 1'b1;
                ctrl.aop       = AOP_FUNCT;
            end
            OPC_LDW: begin
                ctrl.b_is_imm    = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.reg_wr      = 1'b1;
                ctrl.mem_rd      = 1'b1;
                ctrl.aop         = AOP_ADD;
            end
            OPC_STW: begin
                ctrl.b_is_imm = 1'b1;
                ctrl.mem_wr   = 1'b1;
                ctrl.aop      = AOP_ADD;
            end
            OPC_BEQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.aop       = AOP_SUB;
            end
            OPC_ORI: begin
                ctrl.b_is_imm = 1'b1;
                ctrl.imm_zext = 1'b1;
                ctrl.reg_wr   = 1'b1;
                ctrl.aop      = AOP_OR;
            end
            OPC_JMP: begin
                ctrl.is_jump = 1'b1;
            end
            default: begin
                ctrl = '0;
                ctrl.aop = AOP_ADD;
            end
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_cpu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  aop_e            aop,
    input  logic [FN_W-1:0] funct,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output logic [W-1:0]    y,
    output logic            zero,
    output logic            fn_ok
);
    afn_e fn;

    always_comb begin
        fn = AFN_NOP;
        unique case (aop)
            AOP_ADD: fn = AFN_ADD;
            AOP_SUB: fn = AFN_SUB;
            AOP_OR:  fn = AFN_OR;
            AOP_FUNCT: begin
                if (funct == FN_ADDU)      fn = AFN_ADD;
                else if (funct == FN_SUBU) fn = AFN_SUB;
                else                       fn = AFN_NOP;
            end
            default: fn = AFN_NOP;
        endcase
    end

    always_comb begin
        unique case (fn)
            AFN_ADD: y = a + b;
            AFN_SUB: y = a - b;
            AFN_OR:  y = a | b;
            default: y = '0;
        endcase
    end

    assign zero  = (y == '0);
    assign fn_ok = (fn != AFN_NOP);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sc_cpu_pkg::*;
#(
    parameter int N = NREGS,
    parameter int W = XLEN,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra0,
    output logic [W-1:0]  rd0,
    input  logic [AW-1:0] ra1,
    output logic [W-1:0]  rd1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd2
);
    logic [W-1:0] regs [N];

    // Entry 0 is hardwired; all others are individual flops
    assign regs[0] = '0;

    generate
        for (genvar g = 1; g < N; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    regs[g] <= '0;
                else if (we && (waddr == AW'(g)))
                    regs[g] <= wdata;
            end
        end
    endgenerate

    assign rd0 = regs[ra0];
    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];
endmodule

// File: rtl/sc_cpu_core.sv
module sc_cpu_core
    import sc_cpu_pkg::*;
#(
    parameter int IMEM_AW = 6,
    parameter int DMEM_AW = 6,
    localparam int LD_AW  = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW,
    localparam int IWORDS = 1 << IMEM_AW,
    localparam int DWORDS = 1 << DMEM_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic              ld_sel,
    input  logic [LD_AW-1:0]  ld_addr,
    input  logic [XLEN-1:0]   ld_data,
    input  logic [RIDX_W-1:0] dbg_reg_sel,
    output logic [XLEN-1:0]   dbg_reg_val,
    output logic [XLEN-1:0]   dbg_pc
);
    logic [XLEN-1:0] imem [IWORDS];
    logic [XLEN-1:0] dmem [DWORDS];

    logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_tgt, jmp_tgt;
    logic [XLEN-1:0] instr;
    logic [RIDX_W-1:0] rs_idx, rt_idx, rd_idx, wb_idx;
    logic [XLEN-1:0] rs_val, rt_val, imm_x, alu_b, alu_y, wb_val, dm_rdata;
    logic            alu_zero, fn_ok, rf_we, dm_we, br_taken;
    ctrl_t           ctrl;
    logic            unused_shamt;

    // Fetch
    assign instr  = imem[pc_q[IMEM_AW+1:2]];
    assign rs_idx = instr[25:21];
    assign rt_idx = instr[20:16];
    assign rd_idx = instr[15:11];
    assign unused_shamt = ^instr[10:6];

    sc_decoder u_dec (
        .opcode (instr[31:26]),
        .ctrl   (ctrl)
    );

    sc_regfile #(.N(NREGS), .W(XLEN)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .waddr (wb_idx),
        .wdata (wb_val),
        .ra0   (rs_idx),
        .rd0   (rs_val),
        .ra1   (rt_idx),
        .rd1   (rt_val),
        .ra2   (dbg_reg_sel),
        .rd2   (dbg_reg_val)
    );

    assign imm_x = ext_imm(instr[IMM_W-1:0], ctrl.imm_zext);
    assign alu_b = ctrl.b_is_imm ? imm_x : rt_val;

    sc_alu #(.W(XLEN)) u_alu (
        .aop   (ctrl.aop),
        .funct (instr[FN_W-1:0]),
        .a     (rs_val),
        .b     (alu_b),
        .y     (alu_y),
        .zero  (alu_zero),
        .fn_ok (fn_ok)
    );

    // Memory access and write-back
    assign dm_rdata = ctrl.mem_rd ? dmem[alu_y[DMEM_AW+1:2]] : '0;
    assign wb_idx   = ctrl.dst_is_rd ? rd_idx : rt_idx;
    assign wb_val   = ctrl.wb_from_mem ? dm_rdata : alu_y;
    assign rf_we    = ctrl.reg_wr & fn_ok & ~rst;
    assign dm_we    = ctrl.mem_wr & ~rst;

    // Next program counter
    assign pc_plus4 = pc_q + XLEN'(4);
    assign br_tgt   = pc_plus4 + {imm_x[XLEN-3:0], 2'b00};
    assign jmp_tgt  = {pc_plus4[XLEN-1:XLEN-4], instr[JT_W-1:0], 2'b00};
    assign br_taken = ctrl.is_branch & alu_zero;

    always_comb begin
        if (ctrl.is_jump)  pc_next = jmp_tgt;
        else if (br_taken) pc_next = br_tgt;
        else               pc_next = pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    always_ff @(posedge clk) begin
        if (rst && ld_en && !ld_sel)
            imem[ld_addr[IMEM_AW-1:0]] <= ld_data;
    end

    always_ff @(posedge clk) begin
        if (rst && ld_en && ld_sel)
            dmem[ld_addr[DMEM_AW-1:0]] <= ld_data;
        else if (dm_we)
            dmem[alu_y[DMEM_AW+1:2]] <= rt_val;
    end

    assign dbg_pc = pc_q;
endmodule

// File: rtl/sc_cpu_checker.sv
module sc_cpu_checker
    import sc_cpu_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] pc,
    input logic [XLEN-1:0] instr,
    input logic [XLEN-1:0] rs_val,
    input logic [XLEN-1:0] rt_val,
    input logic            rf_we,
    input logic            dm_we
);
    logic [OP_W-1:0] op;
    logic [XLEN-1:0] boff;
    logic            known_op;

    assign op   = instr[31:26];
    assign boff = {{(XLEN-IMM_W-2){instr[15]}}, instr[15:0], 2'b00};
    assign known_op = (op == OPC_REG) || (op == OPC_JMP) || (op == OPC_BEQ) ||
                      (op == OPC_ORI) || (op == OPC_LDW) || (op == OPC_STW);

    a_r6_seq_step: assert property (@(posedge clk) disable iff (rst)
        (op != OPC_BEQ && op != OPC_JMP) |=> pc == $past(pc) + 32'd4);

    a_r7_beq_taken: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_BEQ && rs_val == rt_val) |=> pc == $past(pc) + 32'd4 + $past(boff));

    a_r7_beq_fallthru: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_BEQ && rs_val != rt_val) |=> pc == $past(pc) + 32'd4);

    a_r8_jump_target: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_JMP) |=> pc == {$past(pc[31:28] + {3'b000, &pc[27:2]}), $past(instr[25:0]), 2'b00});

    a_r2_zero_reads: assert property (@(posedge clk) disable iff (rst)
        (instr[25:21] == 5'd0) |-> rs_val == 32'd0);

    a_r9_unknown_quiet: assert property (@(posedge clk) disable iff (rst)
        !known_op |-> (!rf_we && !dm_we));

    a_r10_reset_quiet: assert property (@(posedge clk)
        rst |-> (!rf_we && !dm_we));

    a_r5_single_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rf_we, dm_we}));
endmodule

bind sc_cpu_core sc_cpu_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .pc     (pc_q),
    .instr  (instr),
    .rs_val (rs_val),
    .rt_val (rt_val),
    .rf_we  (rf_we),
    .dm_we  (dm_we)
);

// File: tb/sim_sc_cpu_core.sv
`timescale 1ns/1ps
module sim_sc_cpu_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic        ld_sel = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [4:0]  dbg_reg_sel = '0;
    logic [31:0] dbg_reg_val;
    logic [31:0] dbg_pc;

    always #4 clk = ~clk;

    sc_cpu_core u0 (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel),
        .ld_addr(ld_addr), .ld_data(ld_data),
        .dbg_reg_sel(dbg_reg_sel), .dbg_reg_val(dbg_reg_val), .dbg_pc(dbg_pc)
    );

    typedef struct {
        int          cyc;
        bit          is_reg;
        logic [4:0]  sel;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    done = 1'b0;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'b00000, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction
    function automatic logic [31:0] enc_j(logic [25:0] t);
        return {6'b000010, t};
    endfunction

    task automatic push_pc(int c, logic [31:0] e, string t);
        item_t it;
        it.cyc = c; it.is_reg = 1'b0; it.sel = '0; it.exp = e; it.tag = t;
        sb.push_back(it);
    endtask
    task automatic push_reg(int c, int r, logic [31:0] e, string t);
        item_t it;
        it.cyc = c; it.is_reg = 1'b1; it.sel = 5'(r); it.exp = e; it.tag = t;
        sb.push_back(it);
    endtask

    task automatic load_word(bit s, int a, logic [31:0] d);
        @(posedge clk); #2;
        ld_en = 1'b1; ld_sel = s; ld_addr = 6'(a); ld_data = d;
        @(posedge clk); #2;
        ld_en = 1'b0;
    endtask

    // Monitor: pops expected items when their cycle arrives and compares
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && !done) begin
                while (sb.size() > 0 && sb[0].cyc <= cyc) begin
                    item_t it;
                    logic [31:0] act;
                    it = sb.pop_front();
                    if (it.is_reg) begin
                        dbg_reg_sel = it.sel;
                        #1;
                        act = dbg_reg_val;
                    end else begin
                        act = dbg_pc;
                    end
                    n_cmp++;
                    if (act !== it.exp) begin
                        n_bad++;
                        $display("FAIL %s (cycle %0d): got %h expected %h", it.tag, it.cyc, act, it.exp);
                    end
                end
            end
        end
    end

    // Driver
    initial begin
        // Program load under reset (R10)
        load_word(1'b1, 1, 32'hFFFF_FFFE);
        load_word(1'b1, 3, 32'h0000_DEAD);
        load_word(1'b0, 0,  enc_i(6'b001101, 0, 1, 16'h8005));   // ori r1
        load_word(1'b0, 1,  enc_i(6'b100011, 0, 2, 16'h0004));   // lw r2,4(r0)
        load_word(1'b0, 2,  enc_r(1, 2, 3, 6'b100001));          // addu r3
        load_word(1'b0, 3,  enc_r(0, 1, 4, 6'b100011));          // subu r4
        load_word(1'b0, 4,  enc_i(6'b001101, 0, 5, 16'h0010));   // ori r5,16
        load_word(1'b0, 5,  enc_i(6'b101011, 5, 3, 16'hFFFC));   // sw r3,-4(r5)
        load_word(1'b0, 6,  enc_i(6'b100011, 0, 6, 16'h000C));   // lw r6,12(r0)
        load_word(1'b0, 7,  enc_r(1, 1, 0, 6'b100001));          // addu r0
        load_word(1'b0, 8,  enc_i(6'b000100, 3, 6, 16'h0002));   // beq taken
        load_word(1'b0, 9,  enc_i(6'b001101, 0, 7, 16'h0001));
        load_word(1'b0, 10, enc_i(6'b001101, 0, 7, 16'h0002));
        load_word(1'b0, 11, enc_i(6'b000100, 1, 2, 16'h0005));   // beq not taken
        load_word(1'b0, 12, 32'hFFFF_FFFF);                      // unsupported opcode
        load_word(1'b0, 13, enc_r(1, 1, 8, 6'b000000));          // unsupported funct
        load_word(1'b0, 14, enc_j(26'd20));                      // j word 20
        for (int w = 15; w < 20; w++)
            load_word(1'b0, w, enc_i(6'b001101, 0, 9, 16'h0055));
        load_word(1'b0, 20, enc_i(6'b001101, 0, 10, 16'h0077));
        load_word(1'b0, 21, enc_i(6'b000100, 0, 0, 16'hFFFF));   // self loop

        push_pc(0, 32'd0, "R1 reset pc");
        for (int k = 1; k <= 8; k++) push_pc(k, 32'(4 * k), "R6 sequential");
        push_pc(9,  32'd44, "R7 beq taken");
        push_pc(10, 32'd48, "R7 beq not taken");
        push_pc(11, 32'd52, "R9 unsupported opcode advances");
        push_pc(12, 32'd56, "R9 unsupported funct advances");
        push_pc(13, 32'd80, "R8 jump target");
        push_pc(14, 32'd84, "R6 after jump");
        push_pc(15, 32'd84, "R7 backward self branch");
        push_pc(18, 32'd84, "R10 loader ignored while running (pc)");
        push_pc(19, 32'd84, "R10 loader ignored while running (pc)");
        push_reg(22, 11, 32'd0, "R10 loader ignored while running (r11)");
        push_reg(24, 0,  32'd0, "R2 r0 stays zero");
        push_reg(24, 1,  32'h0000_8005, "R4 ori zero-extends");
        push_reg(24, 2,  32'hFFFF_FFFE, "R5 lw preloaded word");
        push_reg(24, 3,  32'h0000_8003, "R3 addu wraps");
        push_reg(24, 4,  32'hFFFF_7FFB, "R3 subu");
        push_reg(24, 5,  32'h0000_0010, "R4 ori small");
        push_reg(24, 6,  32'h0000_8003, "R5 sw negative offset then lw");
        push_reg(24, 7,  32'd0, "R7 skipped by taken branch");
        push_reg(24, 8,  32'd0, "R9 unsupported funct no write");
        push_reg(24, 9,  32'd0, "R8 skipped by jump");
        push_reg(24, 10, 32'h0000_0077, "R11 tap after jump");
        push_reg(24, 31, 32'd0, "R9 unsupported opcode no write");

        @(posedge clk); #2;
        rst = 1'b0;

        // Attempt a loader write while running (R10)
        repeat (16) @(posedge clk);
        #2;
        ld_en = 1'b1; ld_sel = 1'b0; ld_addr = 6'd21;
        ld_data = enc_i(6'b001101, 0, 11, 16'h0099);
        @(posedge clk); #2;
        ld_en = 1'b0;

        wait (sb.size() == 0);
        @(posedge clk); #2;
        rst = 1'b1;
        push_pc(0, 32'd0, "R1 pc after second reset");
        push_reg(0, 1, 32'd0, "R1 r1 cleared");
        push_reg(0, 10, 32'd0, "R1 r10 cleared");
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        wait (sb.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got %0d items pending expected 0", sb.size());
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule